// File: doc/BRIEF.md
# Serial Flash Controller FIFO and Interrupt Block

This block holds the two byte queues of a serial flash controller and presents them to software through a 16-bit register port. Software writes the command header and any outgoing payload into the data register, which loads the transmit queue. It reads incoming bytes back from the same register, which unloads the receive queue. The serial shifting engine sits beside the block. It takes bytes from the head of the transmit queue and delivers received bytes through a one-cycle push strobe. It also supplies a busy level and a one-cycle pulse for each serial clock period.

A status word reports the fill state of both queues in a fixed bit encoding that drivers poll. Each queue has a programmable watermark that drives a level interrupt. A receive overrun and a receive timeout are latched and stay set until software clears them. The raw interrupt bits pass through a mask register. The masked bits are then combined into a single interrupt line.

Top module: `spi_fifo_regs`

## Requirements
- R1: After reset the status word reads 0x0003, the raw word reads 0x0008, the masked word reads 0x0000, the watermark word reads 0x2020 and `irq` is low.
- R2: The register word addresses are 0 data, 1 status, 2 watermarks, 3 mask, 4 raw, 5 masked and 6 clear. The status bits are bit0 transmit queue empty, bit1 transmit queue not full, bit2 receive queue not empty and bit3 receive queue full.
- R3: Bytes written to the data register appear on `eng_tx_data` in write order, one per `eng_tx_pop`. Bytes pushed by the engine come back from data register reads in push order, with one entry removed per read.
- R4: A data register read while the receive queue is empty returns 0 and moves no pointer. The next pushed byte is the next one read.
- R5: A data write while the transmit queue holds 256 bytes is discarded, and the queue contents do not change.
- R6: An engine push while the receive queue holds 256 bytes is discarded and sets raw bit0 (overrun).
- R7: Raw bit1 (timeout) sets on the 32nd `sclk_tick` pulse counted since the last receive push or pop while the receive queue is not empty. After 31 such pulses it is still clear.
- R8: Raw bit2 is 1 exactly when the receive fill level is at or above the receive watermark.
- R9: Raw bit3 is 1 exactly when the transmit fill level is at or below the transmit watermark.
- R10: The watermark word holds the receive watermark in bits 14:8 and the transmit watermark in bits 6:0. Both reset to 32, and the word reads back as written.
- R11: The masked word equals the raw word ANDed with mask bits 3:0, and `irq` is the OR of the masked bits.
- R12: Writing 1 to bit0 or bit1 of the clear word clears the overrun or timeout latch. Writing bits 2 and 3 has no effect on the watermark bits.
- R13: Status bit4 (busy) is 1 when `eng_busy` is high or the transmit queue is not empty.

Data writes take the byte in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a data read pops the receive queue) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from the address |
| eng_tx_pop | input | 1 | Engine takes the transmit head byte |
| eng_tx_data | output | 8 | Transmit head byte |
| eng_tx_valid | output | 1 | Transmit queue holds at least one byte |
| eng_rx_push | input | 1 | Engine delivers one received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_busy | input | 1 | Engine is shifting |
| sclk_tick | input | 1 | One pulse per serial clock period |
| irq | output | 1 | OR of the masked interrupt bits |

## Verification
A wrong pointer or count in either queue shows up as a byte out of order or a missing byte. It also shows as a status or watermark bit that is wrong on the very next register read. The scoreboards catch such a fault at the first affected pop. A fault in the idle counter moves the timeout by one tick, and the 31-tick and 32-tick reads show it. A latch that clears wrongly or survives a clear shows on the raw read that follows the clear write.

// File: rtl/spi_fifo_pkg.sv
// Shared register map, status and interrupt bit positions for the FIFO block.
// Bit positions are fixed because drivers poll them directly.
package spi_fifo_pkg;
    localparam int REG_W   = 16;
    localparam int ADDR_W  = 3;
    localparam int WM_W    = 7;

    typedef enum logic [ADDR_W-1:0] {
        RA_DATA   = 3'd0,
        RA_STATUS = 3'd1,
        RA_LEVELS = 3'd2,
        RA_MASK   = 3'd3,
        RA_RAW    = 3'd4,
        RA_MASKED = 3'd5,
        RA_CLEAR  = 3'd6
    } reg_addr_e;

    localparam int ST_TXE  = 0;
    localparam int ST_TXNF = 1;
    localparam int ST_RXNE = 2;
    localparam int ST_RXF  = 3;
    localparam int ST_BUSY = 4;

    localparam int IR_OVR  = 0;
    localparam int IR_TMO  = 1;
    localparam int IR_RXW  = 2;
    localparam int IR_TXW  = 3;
    localparam int NUM_IRQ = 4;

    localparam int RXWM_LSB   = 8;
    localparam int TXWM_LSB   = 0;
    localparam int WM_DEFAULT = 32;
endpackage

// File: rtl/sfs_fifo.sv
// Synchronous byte queue with occupancy count.
// Assumes: a push when full is dropped even if a pop occurs in the same
// cycle; a pop when empty does nothing. Head data is combinational.
module sfs_fifo #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Store accepted bytes at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Advance pointers and occupancy on accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/sfs_rx_timeout.sv
// Receive idle timer: counts serial clock ticks while the receive queue is
// non-empty and untouched; latches a flag on the tick that reaches LIMIT.
// Assumes: any push or pop, or an empty queue, restarts the count. Setting
// wins over a clear in the same cycle.
module sfs_rx_timeout #(
    parameter int LIMIT = 32,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic activity,
    input  logic fifo_empty,
    input  logic clr,
    output logic flag
);
    logic [CW-1:0] idle_cnt;
    logic          fire;

    assign fire = tick && !activity && !fifo_empty && (idle_cnt == CW'(LIMIT - 1));

    // Count idle ticks, saturating at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idle_cnt <= '0;
        else if (activity || fifo_empty)
            idle_cnt <= '0;
        else if (tick && idle_cnt != CW'(LIMIT))
            idle_cnt <= idle_cnt + 1'b1;
    end

    // Latch the timeout until software clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (fire)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/sfs_irq.sv
// Interrupt collector: overrun latch, watermark levels, mask register,
// masked view and the combined interrupt line.
// Assumes: the watermark bits are pure levels; only the overrun latch
// lives here, and a set wins over a clear in the same cycle.
module sfs_irq
    import spi_fifo_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ovr_set,
    input  logic               ovr_clr,
    input  logic               tmo_flag,
    input  logic [CNT_W-1:0]   rx_count,
    input  logic [CNT_W-1:0]   tx_count,
    input  logic [WM_W-1:0]    rx_wm,
    input  logic [WM_W-1:0]    tx_wm,
    input  logic               mask_wr,
    input  logic [NUM_IRQ-1:0] mask_wdata,
    output logic [NUM_IRQ-1:0] raw,
    output logic [NUM_IRQ-1:0] mask,
    output logic [NUM_IRQ-1:0] masked,
    output logic               irq
);
    logic ovr_flag;

    // Latch receive overrun until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr_flag <= 1'b0;
        else if (ovr_set)
            ovr_flag <= 1'b1;
        else if (ovr_clr)
            ovr_flag <= 1'b0;
    end

    // Hold the software interrupt mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (mask_wr)
            mask <= mask_wdata;
    end

    // Assemble the raw interrupt word from latches and levels.
    always_comb begin
        raw         = '0;
        raw[IR_OVR] = ovr_flag;
        raw[IR_TMO] = tmo_flag;
        raw[IR_RXW] = (rx_count >= CNT_W'(rx_wm));
        raw[IR_TXW] = (tx_count <= CNT_W'(tx_wm));
    end

    assign masked = raw & mask;
    assign irq    = |masked;
endmodule

// File: rtl/spi_fifo_regs.sv
// Register front end of the flash controller queues: decodes the 16-bit
// port, owns the watermark register, routes the engine side to the queues
// and assembles the status and interrupt words.
// Assumes: reg_rdata is combinational from reg_addr; a data read pops the
// receive queue at the clock edge that ends the read strobe.
module spi_fifo_regs
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH     = 256,
    parameter int DATA_W    = 8,
    parameter int TMO_TICKS = 32,
    localparam int CNT_W    = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              eng_tx_pop,
    output logic [DATA_W-1:0] eng_tx_data,
    output logic              eng_tx_valid,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              eng_busy,
    input  logic              sclk_tick,
    output logic              irq
);
    logic [CNT_W-1:0]   tx_count, rx_count;
    logic               tx_empty, tx_full, rx_empty, rx_full;
    logic [DATA_W-1:0]  rx_head;
    logic               tx_push, rx_pop, clr_wr, mask_wr, tmo_flag;
    logic [WM_W-1:0]    rx_wm, tx_wm;
    logic [NUM_IRQ-1:0] raw_bits, mask_bits, masked_bits;
    logic [REG_W-1:0]   status_word;
    logic               unused_wdata;

    assign unused_wdata = ^{reg_wdata[REG_W-1], reg_wdata[RXWM_LSB-1]};

    assign tx_push = reg_wr && (reg_addr == RA_DATA);
    assign rx_pop  = reg_rd && (reg_addr == RA_DATA) && !rx_empty;
    assign clr_wr  = reg_wr && (reg_addr == RA_CLEAR);
    assign mask_wr = reg_wr && (reg_addr == RA_MASK);

    sfs_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(reg_wdata[DATA_W-1:0]),
        .pop(eng_tx_pop), .head(eng_tx_data),
        .count(tx_count), .empty(tx_empty), .full(tx_full)
    );

    sfs_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(eng_rx_push), .push_data(eng_rx_data),
        .pop(rx_pop), .head(rx_head),
        .count(rx_count), .empty(rx_empty), .full(rx_full)
    );

    sfs_rx_timeout #(.LIMIT(TMO_TICKS)) u_rx_tmo (
        .clk(clk), .rst_n(rst_n),
        .tick(sclk_tick), .activity(eng_rx_push || rx_pop),
        .fifo_empty(rx_empty), .clr(clr_wr && reg_wdata[IR_TMO]),
        .flag(tmo_flag)
    );

    sfs_irq #(.CNT_W(CNT_W)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .ovr_set(eng_rx_push && rx_full), .ovr_clr(clr_wr && reg_wdata[IR_OVR]),
        .tmo_flag(tmo_flag),
        .rx_count(rx_count), .tx_count(tx_count),
        .rx_wm(rx_wm), .tx_wm(tx_wm),
        .mask_wr(mask_wr), .mask_wdata(reg_wdata[NUM_IRQ-1:0]),
        .raw(raw_bits), .mask(mask_bits), .masked(masked_bits), .irq(irq)
    );

    assign eng_tx_valid = !tx_empty;

    // Hold both watermarks, reset to the default level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_wm <= WM_W'(WM_DEFAULT);
            tx_wm <= WM_W'(WM_DEFAULT);
        end else if (reg_wr && reg_addr == RA_LEVELS) begin
            rx_wm <= reg_wdata[RXWM_LSB +: WM_W];
            tx_wm <= reg_wdata[TXWM_LSB +: WM_W];
        end
    end

    // Build the polled status word.
    always_comb begin
        status_word          = '0;
        status_word[ST_TXE]  = tx_empty;
        status_word[ST_TXNF] = !tx_full;
        status_word[ST_RXNE] = !rx_empty;
        status_word[ST_RXF]  = rx_full;
        status_word[ST_BUSY] = eng_busy || !tx_empty;
    end

    // Select read data by register address.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_DATA:   reg_rdata = rx_empty ? '0 : REG_W'(rx_head);
            RA_STATUS: reg_rdata = status_word;
            RA_LEVELS: begin
                reg_rdata[RXWM_LSB +: WM_W] = rx_wm;
                reg_rdata[TXWM_LSB +: WM_W] = tx_wm;
            end
            RA_MASK:   reg_rdata = REG_W'(mask_bits);
            RA_RAW:    reg_rdata = REG_W'(raw_bits);
            RA_MASKED: reg_rdata = REG_W'(masked_bits);
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_fifo_regs_chk.sv
// Property checker for spi_fifo_regs, attached by bind below.
// Assumes the register address encoding of spi_fifo_pkg.
module spi_fifo_regs_chk #(
    parameter int DEPTH = 256,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [2:0]       reg_addr,
    input logic [1:0]       clr_bits,
    input logic [15:0]      reg_rdata,
    input logic             eng_rx_push,
    input logic             eng_tx_pop,
    input logic             irq,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] tx_count,
    input logic [3:0]       raw_bits,
    input logic [3:0]       mask_bits
);
    logic data_rd, data_wr, clr_wr;
    assign data_rd = reg_rd && reg_addr == 3'd0;
    assign data_wr = reg_wr && reg_addr == 3'd0;
    assign clr_wr  = reg_wr && reg_addr == 3'd6;

    // R6
    rx_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_rx_push && rx_count == CNT_W'(DEPTH) && !data_rd)
        |=> (rx_count == CNT_W'(DEPTH) && raw_bits[0]));

    // R5
    tx_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && tx_count == CNT_W'(DEPTH) && !eng_tx_pop)
        |=> (tx_count == CNT_W'(DEPTH)));

    // R4
    rx_empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && rx_count == '0) |-> (reg_rdata == 16'h0000));

    // R4
    rx_empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && rx_count == '0 && !eng_rx_push) |=> (rx_count == '0));

    // R3
    rx_pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !eng_rx_push && rx_count != '0)
        |=> (rx_count == $past(rx_count) - 1'b1));

    // R11
    irq_masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_bits == 4'h0) |-> !irq);

    // R12
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_bits[0] && !(eng_rx_push && rx_count == CNT_W'(DEPTH)))
        |=> !raw_bits[0]);
endmodule

bind spi_fifo_regs spi_fifo_regs_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .clr_bits(reg_wdata[1:0]), .reg_rdata(reg_rdata),
    .eng_rx_push(eng_rx_push), .eng_tx_pop(eng_tx_pop), .irq(irq),
    .rx_count(rx_count), .tx_count(tx_count),
    .raw_bits(raw_bits), .mask_bits(mask_bits)
);

// File: tb/spi_fifo_regs_bench.sv
// Scoreboard bench: driver tasks queue expected bytes, the transmit
// monitor and the data-read task compare what the design produces.
module spi_fifo_regs_bench;
    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        eng_tx_pop = 1'b0;
    logic [7:0]  eng_tx_data;
    logic        eng_tx_valid;
    logic        eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_data = 8'h0;
    logic        eng_busy = 1'b0;
    logic        sclk_tick = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #5 clk = ~clk;

    spi_fifo_regs u_spi_fifo_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_tx_valid(eng_tx_valid), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .eng_busy(eng_busy),
        .sclk_tick(sclk_tick), .irq(irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #3 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    // Driver: write one transmit byte, queue it if it should be kept.
    task automatic tx_write(input logic [7:0] b, input bit keep);
        if (keep) txq.push_back(b);
        reg_write(3'd0, {8'h00, b});
    endtask

    // Driver: engine delivers one byte, queue it if it should be kept.
    task automatic rx_push(input logic [7:0] b, input bit keep);
        if (keep) rxq.push_back(b);
        eng_rx_data = b; eng_rx_push = 1'b1;
        @(posedge clk); #1;
        eng_rx_push = 1'b0;
    endtask

    // Pop one receive byte through the data register and compare.
    task automatic rx_read_check(input string tag);
        logic [15:0] d;
        logic [7:0] e;
        reg_read(3'd0, d);
        e = (rxq.size() != 0) ? rxq.pop_front() : 8'h00;
        check(tag, d, {8'h00, e});
    endtask

    task automatic tx_pops(input int n);
        eng_tx_pop = 1'b1;
        repeat (n) @(posedge clk);
        #1 eng_tx_pop = 1'b0;
    endtask

    // Monitor: every engine pop must present the oldest written byte (R3).
    always @(negedge clk) begin
        if (rst_n && eng_tx_pop) begin
            checks++;
            if (txq.size() == 0) begin
                errors++;
                $display("FAIL R3 tx pop with empty scoreboard actual %h expected none", eng_tx_data);
            end else begin
                logic [7:0] e;
                e = txq.pop_front();
                if (eng_tx_data !== e) begin
                    errors++;
                    $display("FAIL R3 tx order actual %h expected %h", eng_tx_data, e);
                end
            end
        end
    end

    initial begin
        #2ms;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset values
        reg_read(3'd1, d); check("R1 status", d, 16'h0003);
        reg_read(3'd4, d); check("R1 raw", d, 16'h0008);
        reg_read(3'd5, d); check("R1 masked", d, 16'h0000);
        reg_read(3'd2, d); check("R1 R10 levels default", d, 16'h2020);
        check("R1 irq", {15'h0, irq}, 16'h0);

        // R4 empty read returns zero, pointers unchanged
        reg_read(3'd0, d); check("R4 empty read", d, 16'h0000);
        rx_push(8'h5A, 1'b1);
        reg_read(3'd1, d); check("R2 rx not empty", d & 16'h000C, 16'h0004);
        rx_read_check("R4 first byte after empty read");

        // R3 receive order with several bytes
        rx_push(8'h11, 1'b1); rx_push(8'h22, 1'b1); rx_push(8'hC3, 1'b1);
        for (int i = 0; i < 3; i++) rx_read_check("R3 rx order");
        reg_read(3'd1, d); check("R2 rx drained", d & 16'h000C, 16'h0000);

        // R10 watermark layout
        reg_write(3'd2, 16'h0402);
        reg_read(3'd2, d); check("R10 levels readback", d, 16'h0402);

        // R8 receive watermark at 4
        for (int i = 0; i < 3; i++) rx_push(8'h30 + 8'(i), 1'b1);
        reg_read(3'd4, d); check("R8 below rx wm", d & 16'h0004, 16'h0000);
        rx_push(8'h33, 1'b1);
        reg_read(3'd4, d); check("R8 at rx wm", d & 16'h0004, 16'h0004);
        for (int i = 0; i < 4; i++) rx_read_check("R3 rx drain after wm");

        // R9 transmit watermark at 2, R13 busy
        tx_write(8'hA1, 1'b1); tx_write(8'hA2, 1'b1); tx_write(8'hA3, 1'b1);
        reg_read(3'd4, d); check("R9 above tx wm", d & 16'h0008, 16'h0000);
        reg_read(3'd1, d); check("R13 busy from tx data", d & 16'h0011, 16'h0010);
        tx_pops(1);
        reg_read(3'd4, d); check("R9 at tx wm", d & 16'h0008, 16'h0008);
        tx_pops(2);
        reg_read(3'd1, d); check("R13 idle", d & 16'h0011, 16'h0001);
        eng_busy = 1'b1;
        reg_read(3'd1, d); check("R13 busy from engine", d & 16'h0010, 16'h0010);
        eng_busy = 1'b0;

        // R5 transmit full, extra write dropped
        for (int i = 0; i < DEPTH; i++) tx_write(8'(i * 7 + 3), 1'b1);
        reg_read(3'd1, d); check("R5 R2 tx full status", d & 16'h0003, 16'h0000);
        tx_write(8'hEE, 1'b0);
        tx_pops(DEPTH);
        reg_read(3'd1, d); check("R5 tx empty after drain", d & 16'h0003, 16'h0003);
        check("R5 tx valid low", {15'h0, eng_tx_valid}, 16'h0);

        // R6 receive overrun, R12 clear
        for (int i = 0; i < DEPTH; i++) rx_push(8'(i * 5 + 1), 1'b1);
        reg_read(3'd1, d); check("R2 rx full", d & 16'h000C, 16'h000C);
        reg_read(3'd4, d); check("R6 no overrun yet", d & 16'h0001, 16'h0000);
        rx_push(8'hA5, 1'b0);
        reg_read(3'd4, d); check("R6 overrun set", d & 16'h0001, 16'h0001);
        reg_write(3'd6, 16'h0001);
        reg_read(3'd4, d); check("R12 overrun cleared", d & 16'h0001, 16'h0000);
        for (int i = 0; i < DEPTH; i++) rx_read_check("R6 rx contents after drop");
        reg_read(3'd1, d); check("R6 rx empty after drain", d & 16'h0004, 16'h0000);

        // R11 mask and irq, R12 watermark bits not clearable
        reg_write(3'd3, 16'h0008);
        reg_read(3'd5, d); check("R11 masked tx wm", d, 16'h0008);
        check("R11 irq high", {15'h0, irq}, 16'h0001);
        reg_write(3'd6, 16'h000C);
        reg_read(3'd4, d); check("R12 wm bit survives clear", d & 16'h0008, 16'h0008);
        reg_write(3'd3, 16'h0001);
        reg_read(3'd5, d); check("R11 masked off", d, 16'h0000);
        check("R11 irq low", {15'h0, irq}, 16'h0000);

        // R7 receive timeout after 32 idle ticks
        rx_push(8'h7E, 1'b1);
        sclk_tick = 1'b1;
        repeat (31) @(posedge clk);
        #1 sclk_tick = 1'b0;
        reg_read(3'd4, d); check("R7 no timeout at 31", d & 16'h0002, 16'h0000);
        sclk_tick = 1'b1;
        @(posedge clk); #1 sclk_tick = 1'b0;
        reg_read(3'd4, d); check("R7 timeout at 32", d & 16'h0002, 16'h0002);
        reg_write(3'd6, 16'h0002);
        reg_read(3'd4, d); check("R12 timeout cleared", d & 16'h0002, 16'h0000);
        rx_read_check("R7 byte after timeout");

        check("R3 tx scoreboard empty", 16'(txq.size()), 16'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule